// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a simple request/ready bus master and a 32-bit word-addressed memory or register target. It claims an alias address window in which every bit of every target word has a word-sized address of its own. Software that writes an alias address changes exactly one bit of the target word, and the other 31 bits stay as they were. Software that reads an alias address gets that one bit back in bit 0.

An alias write becomes a read of the target word, a one-bit merge, and a write of the merged word back to the same address. The bridge raises a lock output for the whole sequence so that an arbiter can keep other masters off the target in between. An alias read costs one target read and no write. Any address outside the window is forwarded to the target unchanged as a single access.

Within the window, bits [6:2] of the offset select the bit and the bits above them select the word. Bits [1:0] of the offset are ignored. The alias base, the target base and the target size are parameters.

Top module: `bitband_bridge`

## Requirements
- R1: An address A with ALIAS_BASE <= A < ALIAS_BASE + 32*TGT_BYTES is an alias access. Its bit index is ((A - ALIAS_BASE) >> 2) mod 32, and its target word address is TGT_BASE + 4*((A - ALIAS_BASE) >> 7). Every other address is a pass-through access.
- R2: An alias read returns the selected target bit in m_rdata[0], with m_rdata[31:1] zero. It makes exactly one target read and no target write.
- R3: An alias write reads the target word and then writes back the same address with the selected bit replaced and the other 31 bits unchanged.
- R4: t_lock is high on every cycle in which t_req is high for an alias access, from the target read through the acceptance of the target write. t_lock stays low for pass-through accesses and when the bridge is idle.
- R5: m_ready stays low while any target access of the transaction is outstanding. It then pulses high for exactly one cycle per master transaction.
- R6: A pass-through access makes one target access with m_addr, m_we and m_wdata forwarded unchanged. For a read, t_rdata is returned unchanged on m_rdata.
- R7: While reset is asserted, and until a request arrives, t_req, t_lock and m_ready are low.
- R8: On an alias write only m_wdata[0] supplies the new bit value. Bits [31:1] of m_wdata have no effect on the target word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m_req | input | 1 | Master request, held until m_ready |
| m_we | input | 1 | Master write enable |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Read data to master, valid with m_ready |
| m_ready | output | 1 | One-cycle completion pulse to master |
| t_req | output | 1 | Target request, held until t_ready |
| t_we | output | 1 | Target write enable |
| t_addr | output | 32 | Target byte address |
| t_wdata | output | 32 | Target write data |
| t_rdata | input | 32 | Target read data, valid with t_ready |
| t_ready | input | 1 | Target completion pulse |
| t_lock | output | 1 | Held high across an alias access so other masters are kept out |

## Verification
The bench aims at the window edges: bit 0 of the first word, bit 31 of the last word, the address just below the alias base, and the first address past the window. An off-by-one in the decoder would either corrupt a target word or turn an alias access into a raw pass-through. Alias writes carry data with high bits set, so a bridge that took the full write data, or that did not preserve the neighbouring bits, would leave a wrong word in the target memory model. Per-transaction counts of target reads, target writes, unlocked request cycles and ready pulses expose a bridge that writes on an alias read, drops the lock between read and write, or answers the master before the write has landed. The target inserts random wait states, which also exposes a bridge that answers early.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = $clog2(DW);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_ARD,
    ST_AWR,
    ST_RSP
  } seq_state_e;
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter logic [AW-1:0] ALIAS_BASE = 32'h2200_0000,
  parameter logic [AW-1:0] TGT_BASE   = 32'h2000_0000,
  parameter int unsigned   TGT_BYTES  = 1024
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [BW-1:0] bit_idx,
  output logic [AW-1:0] word_addr
);
  localparam logic [AW-1:0] WIN_BYTES = AW'(TGT_BYTES * DW);
  localparam int            WORD_SH   = BW + 2;

  logic [AW-1:0] offs;

  always_comb begin
    offs      = addr - ALIAS_BASE;
    hit       = (addr >= ALIAS_BASE) && (offs < WIN_BYTES);
    bit_idx   = BW'(offs >> 2);
    word_addr = TGT_BASE + ((offs >> WORD_SH) << 2);
  end
endmodule

// File: rtl/bb_merge.sv
module bb_merge
  import bb_pkg::*;
(
  input  logic [DW-1:0] word_in,
  input  logic [BW-1:0] sel,
  input  logic          new_val,
  output logic [DW-1:0] word_out,
  output logic          picked
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign word_out[i] = (sel == BW'(i)) ? new_val : word_in[i];
  end

  assign picked = word_in[sel];

  always_comb begin
    // R3: at most one bit differs, and it carries the new value
    a_r3_one_bit_changes : assert ($countones(word_out ^ word_in) <= 1);
    a_r3_new_bit_placed  : assert (word_out[sel] == new_val);
  end
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  output logic [DW-1:0] m_rdata,
  output logic          m_ready,
  input  logic          dec_hit,
  input  logic [BW-1:0] dec_bit,
  input  logic [AW-1:0] dec_word,
  input  logic [DW-1:0] mrg_word,
  input  logic          mrg_bit,
  output logic [BW-1:0] cur_bit,
  output logic          cur_val,
  output logic          t_req,
  output logic          t_we,
  output logic [AW-1:0] t_addr,
  output logic [DW-1:0] t_wdata,
  input  logic [DW-1:0] t_rdata,
  input  logic          t_ready,
  output logic          t_lock
);
  seq_state_e    state_q, state_d;
  logic          cap_en, buf_en;
  logic [DW-1:0] buf_d;
  logic          alias_q, we_q, val_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, buf_q;
  logic [BW-1:0] bit_q;

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    buf_en  = 1'b0;
    buf_d   = buf_q;
    unique case (state_q)
      ST_IDLE: if (m_req) begin
        cap_en  = 1'b1;
        state_d = dec_hit ? ST_ARD : ST_PASS;
      end
      ST_PASS: if (t_ready) begin
        buf_en  = 1'b1;
        buf_d   = t_rdata;
        state_d = ST_RSP;
      end
      ST_ARD: if (t_ready) begin
        buf_en = 1'b1;
        if (we_q) begin
          buf_d   = mrg_word;
          state_d = ST_AWR;
        end else begin
          buf_d   = DW'(mrg_bit);
          state_d = ST_RSP;
        end
      end
      ST_AWR: if (t_ready) state_d = ST_RSP;
      ST_RSP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      alias_q <= dec_hit;
      we_q    <= m_we;
      addr_q  <= dec_hit ? dec_word : m_addr;
      wdata_q <= m_wdata;
      bit_q   <= dec_bit;
      val_q   <= m_wdata[0];
    end
    if (buf_en) buf_q <= buf_d;
  end

  assign t_req   = (state_q == ST_PASS) || (state_q == ST_ARD) || (state_q == ST_AWR);
  assign t_we    = ((state_q == ST_PASS) && we_q) || (state_q == ST_AWR);
  assign t_addr  = addr_q;
  assign t_wdata = (state_q == ST_AWR) ? buf_q : wdata_q;
  assign t_lock  = (state_q == ST_ARD) || (state_q == ST_AWR);
  assign m_ready = (state_q == ST_RSP);
  assign m_rdata = buf_q;
  assign cur_bit = bit_q;
  assign cur_val = val_q;

  // R5: no completion while the target is still busy
  a_r5_ready_after_target : assert property (@(posedge clk) disable iff (!rst_n)
    t_req |-> !m_ready);
  // R4: lock only falls right after a target handshake
  a_r4_lock_held_to_end : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(t_lock) |-> $past(t_ready));
  // R6: unlocked target traffic mirrors the master
  a_r6_pass_forward : assert property (@(posedge clk) disable iff (!rst_n)
    (t_req && !t_lock) |-> (t_addr == m_addr && t_we == m_we && t_wdata == m_wdata));
  // R2: alias read answer has only bit 0 populated
  a_r2_read_bit0_only : assert property (@(posedge clk) disable iff (!rst_n)
    (m_ready && alias_q && !we_q) |-> (m_rdata[DW-1:1] == '0));
  // R2: no target write during an alias read
  a_r2_read_no_write : assert property (@(posedge clk) disable iff (!rst_n)
    (t_lock && !we_q) |-> !t_we);
  // R3: write-back goes to the word just read
  a_r3_same_word : assert property (@(posedge clk) disable iff (!rst_n)
    (t_lock && t_we) |-> $stable(t_addr));
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter logic [31:0] TGT_BASE   = 32'h2000_0000,
  parameter int unsigned TGT_BYTES  = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        m_req,
  input  logic        m_we,
  input  logic [31:0] m_addr,
  input  logic [31:0] m_wdata,
  output logic [31:0] m_rdata,
  output logic        m_ready,
  output logic        t_req,
  output logic        t_we,
  output logic [31:0] t_addr,
  output logic [31:0] t_wdata,
  input  logic [31:0] t_rdata,
  input  logic        t_ready,
  output logic        t_lock
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic          dec_hit, mrg_bit, cur_val;
  logic [BW-1:0] dec_bit, cur_bit;
  logic [AW-1:0] dec_word;
  logic [DW-1:0] mrg_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  bb_decode #(
    .ALIAS_BASE(ALIAS_BASE),
    .TGT_BASE  (TGT_BASE),
    .TGT_BYTES (TGT_BYTES)
  ) u_dec (
    .addr     (m_addr),
    .hit      (dec_hit),
    .bit_idx  (dec_bit),
    .word_addr(dec_word)
  );

  bb_merge u_mrg (
    .word_in (t_rdata),
    .sel     (cur_bit),
    .new_val (cur_val),
    .word_out(mrg_word),
    .picked  (mrg_bit)
  );

  bb_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_rdata (m_rdata),
    .m_ready (m_ready),
    .dec_hit (dec_hit),
    .dec_bit (dec_bit),
    .dec_word(dec_word),
    .mrg_word(mrg_word),
    .mrg_bit (mrg_bit),
    .cur_bit (cur_bit),
    .cur_val (cur_val),
    .t_req   (t_req),
    .t_we    (t_we),
    .t_addr  (t_addr),
    .t_wdata (t_wdata),
    .t_rdata (t_rdata),
    .t_ready (t_ready),
    .t_lock  (t_lock)
  );
endmodule

// File: tb/sim_bitband_bridge.sv
module sim_bitband_bridge;
  localparam logic [31:0] ALIAS = 32'h2200_0000;
  localparam logic [31:0] TBASE = 32'h2000_0000;
  localparam int          TBY   = 1024;
  localparam int          NW    = TBY / 4;
  localparam logic [31:0] WIN   = 32'(TBY * 32);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_req, m_we;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic        m_ready;
  logic        t_req, t_we, t_ready, t_lock;
  logic [31:0] t_addr, t_wdata, t_rdata;

  always #5 clk = ~clk;

  bitband_bridge #(.ALIAS_BASE(ALIAS), .TGT_BASE(TBASE), .TGT_BYTES(TBY)) u0 (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .t_req(t_req),
    .t_we(t_we), .t_addr(t_addr), .t_wdata(t_wdata), .t_rdata(t_rdata),
    .t_ready(t_ready), .t_lock(t_lock)
  );

  function automatic logic [31:0] seed_word(int i);
    return (32'(i) * 32'h9E37_79B9) ^ 32'hA5A5_0F0F;
  endfunction

  // target memory with random wait states
  logic [31:0] mem [NW];
  logic        busy;
  int unsigned dly;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_ready <= 1'b0;
      busy    <= 1'b0;
      dly     <= 0;
      t_rdata <= '0;
      for (int i = 0; i < NW; i++) mem[i] <= seed_word(i);
    end else begin
      t_ready <= 1'b0;
      if (t_req && !t_ready) begin
        if (!busy) begin
          busy <= 1'b1;
          dly  <= $urandom % 3;
        end else if (dly == 0) begin
          busy    <= 1'b0;
          t_ready <= 1'b1;
          if (t_we) mem[t_addr[9:2]] <= t_wdata;
          else      t_rdata <= mem[t_addr[9:2]];
        end else begin
          dly <= dly - 1;
        end
      end
    end
  end

  // monitor, sampled mid-cycle
  int          rd_n, wr_n, nolock_n, lock_n, rdy_n;
  logic [31:0] last_raddr, last_waddr;
  initial begin
    rd_n = 0; wr_n = 0; nolock_n = 0; lock_n = 0; rdy_n = 0;
    last_raddr = '0; last_waddr = '0;
  end
  always @(negedge clk) begin
    if (t_req && t_ready) begin
      if (t_we) begin wr_n++; last_waddr = t_addr; end
      else      begin rd_n++; last_raddr = t_addr; end
    end
    if (t_req && !t_lock) nolock_n++;
    if (t_lock) lock_n++;
    if (m_ready) rdy_n++;
  end

  int          checks = 0, errors = 0;
  logic [31:0] exp_mem [NW];
  int          s_rd, s_wr, s_nl, s_lk, s_rdy;
  logic [31:0] rd_val;
  bit          hung;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [31:0] a, input logic [31:0] d);
    int n;
    s_rd = rd_n; s_wr = wr_n; s_nl = nolock_n; s_lk = lock_n; s_rdy = rdy_n;
    @(negedge clk);
    m_req = 1'b1; m_we = we; m_addr = a; m_wdata = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!m_ready && n < 100);
    if (!m_ready) begin
      hung = 1'b1;
      chk("R5 ready timeout", 32'd0, 32'd1);
    end
    rd_val = m_rdata;
    m_req = 1'b0; m_we = 1'b0;
    @(negedge clk);
    chk("R5 one ready pulse", 32'(rdy_n - s_rdy), 32'd1);
  endtask

  function automatic logic [31:0] alias_addr(int w, int b);
    return ALIAS + 32'(w) * 32'd128 + 32'(b) * 32'd4;
  endfunction

  task automatic alias_wr(input int w, input int b, input logic [31:0] d);
    xfer(1'b1, alias_addr(w, b), d);
    exp_mem[w][b] = d[0];
    chk("R3 one target read", 32'(rd_n - s_rd), 32'd1);
    chk("R3 one target write", 32'(wr_n - s_wr), 32'd1);
    chk("R1 write word address", last_waddr, TBASE + 32'(w) * 32'd4);
    chk("R3 R8 target word", mem[w], exp_mem[w]);
    chk("R4 no unlocked alias cycle", 32'(nolock_n - s_nl), 32'd0);
  endtask

  task automatic alias_rd(input int w, input int b);
    xfer(1'b0, alias_addr(w, b), 32'hFFFF_FFFF);
    chk("R2 alias read data", rd_val, {31'd0, exp_mem[w][b]});
    chk("R2 one target read", 32'(rd_n - s_rd), 32'd1);
    chk("R2 no target write", 32'(wr_n - s_wr), 32'd0);
    chk("R1 read word address", last_raddr, TBASE + 32'(w) * 32'd4);
    chk("R4 alias read locked", 32'(nolock_n - s_nl), 32'd0);
  endtask

  task automatic pass_wr(input logic [31:0] a, input logic [31:0] d);
    xfer(1'b1, a, d);
    exp_mem[a[9:2]] = d;
    chk("R6 pass one write", 32'(wr_n - s_wr), 32'd1);
    chk("R6 pass no read", 32'(rd_n - s_rd), 32'd0);
    chk("R6 pass address", last_waddr, a);
    chk("R4 pass unlocked", 32'(lock_n - s_lk), 32'd0);
    chk("R6 pass data stored", mem[a[9:2]], d);
  endtask

  task automatic pass_rd(input logic [31:0] a);
    xfer(1'b0, a, 32'd0);
    chk("R6 pass read data", rd_val, exp_mem[a[9:2]]);
    chk("R6 pass one read", 32'(rd_n - s_rd), 32'd1);
    chk("R6 pass address", last_raddr, a);
    chk("R4 pass unlocked", 32'(lock_n - s_lk), 32'd0);
  endtask

  initial begin
    hung = 1'b0;
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    for (int i = 0; i < NW; i++) exp_mem[i] = seed_word(i);
    rst_n = 1'b0; m_req = 1'b0; m_we = 1'b0; m_addr = '0; m_wdata = '0;
    repeat (3) @(negedge clk);
    // R7: quiet during reset
    chk("R7 t_req in reset", 32'(t_req), 32'd0);
    chk("R7 t_lock in reset", 32'(t_lock), 32'd0);
    chk("R7 m_ready in reset", 32'(m_ready), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 idle after reset", {29'd0, t_req, t_lock, m_ready}, 32'd0);

    // directed corners
    alias_wr(0, 0, 32'h0000_0001);            // R1 first bit of window
    alias_wr(0, 0, 32'hFFFF_FFFE);            // R8 high bits ignored -> clear
    alias_wr(NW - 1, 31, 32'h0000_0001);      // R1 last bit of window
    alias_rd(NW - 1, 31);
    alias_wr(NW - 1, 31, 32'h8000_0000);      // R8 bit 31 of data ignored
    alias_rd(NW - 1, 31);
    pass_wr(TBASE + 32'd20, 32'hDEAD_BEEF);   // R6
    alias_rd(5, 0);
    alias_rd(5, 1);
    pass_wr(ALIAS - 32'd4, 32'h1234_5678);    // R1 just below window
    pass_rd(ALIAS - 32'd4);
    pass_wr(ALIAS + WIN, 32'h0BAD_F00D);      // R1 first address past window
    pass_rd(TBASE);
    xfer(1'b1, alias_addr(3, 7) + 32'd3, 32'd1); // R1 offset bits [1:0] ignored
    exp_mem[3][7] = 1'b1;
    chk("R1 low offset bits ignored", mem[3], exp_mem[3]);

    // random mix
    for (int k = 0; k < 400 && !hung; k++) begin
      int op, w, b;
      op = int'($urandom % 4);
      w  = int'($urandom % NW);
      b  = int'($urandom % 32);
      case (op)
        0: alias_wr(w, b, $urandom);
        1: alias_rd(w, b);
        2: pass_wr(TBASE + 32'(w) * 32'd4, $urandom);
        default: pass_rd(TBASE + 32'(w) * 32'd4);
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule